// File: doc/BRIEF.md
# Endpoint FIFO access handshake controller

This block is the command and status register through which a microcontroller gains access to one endpoint FIFO of a USB device. Firmware selects an endpoint and raises a request bit. It then signals the end of the transfer with a direction bit. For a write the direction bit falls from 1 to 0 while the request stays high. For a read it rises from 0 to 1 while the request stays high. Each such edge produces a single-cycle commit or release pulse toward the FIFO logic, addressed to the selected endpoint.

Firmware may also flush the selected FIFO at any time, whether or not it is ready. A flushed endpoint then drives a forced transmit-error line toward the USB engine, so that a host IN sees an underrun. The line stays high until firmware next commits a write to that endpoint. Status bits report three things: whether the selected FIFO is ready, whether a SETUP packet is held, and whether a zero-length packet arrived on the selected endpoint. A USB bus reset clears the whole register.

Register layout (REG_W = 7 + EPW bits): bit 0 request, bit 1 direction, bit 2 flush command (reads 0), bit 3 setup flag, bit 4 ready (read-only), bit 5 zero-length flag (read-only), bit 6 forced-error state of the selected endpoint (read-only), bits [7 +: EPW] endpoint select.

Top module: `epfifo_access_ctl`

## Requirements
- R1: Asserting rst_n low or bus_reset high for one clock clears request, direction, select, setup flag, all zero-length flags and all forced-error lines, so reg_rdata reads 0.
- R2: A write stores bits 0, 1 and the select field, which read back on reg_rdata. The select field is ignored while the stored request bit is 1, so ep_sel cannot move during an access.
- R3: A write that keeps the request at 1 while the direction goes from 1 to 0 gives a one-cycle fifo_commit pulse in the cycle after the write, with ep_sel naming the endpoint.
- R4: A write that keeps the request at 1 while the direction goes from 0 to 1 gives a one-cycle fifo_release pulse in the cycle after the write. Commit and release are never high together.
- R5: A direction change made while the request is 0, or in the same write that raises or drops the request, produces no commit and no release.
- R6: Writing 1 to bit 2 gives a one-cycle fifo_flush pulse for the endpoint named by that write's select field, regardless of fifo_ready. It sets force_txerr for that endpoint. Bit 2 always reads 0.
- R7: force_txerr of an endpoint stays high until a commit (R3) to that endpoint. Commits to other endpoints leave it unchanged.
- R8: A setup_rx strobe sets bit 3. A write with bit 3 at 0 clears it, and a write with bit 3 at 1 leaves it unchanged. A strobe in the same cycle as a clearing write leaves the flag set.
- R9: A zlp_rx strobe sets the zero-length flag of endpoint zlp_ep. A fifo_rd_strobe clears the flag of the selected endpoint only. Bit 5 shows the flag of the selected endpoint.
- R10: Bit 4 equals fifo_ready[ep_sel] in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset | input | 1 | USB bus reset, synchronous clear |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data |
| fifo_ready | input | NUM_EP | Per-endpoint FIFO ready status |
| setup_rx | input | 1 | Engine strobe: SETUP packet stored |
| zlp_rx | input | 1 | Engine strobe: zero-length packet received |
| zlp_ep | input | EPW | Endpoint of the zero-length packet |
| fifo_rd_strobe | input | 1 | MCU read of a FIFO data byte |
| ep_sel | output | EPW | Selected endpoint |
| fifo_commit | output | 1 | Write-transfer end pulse |
| fifo_release | output | 1 | Read-transfer end pulse |
| fifo_flush | output | 1 | Flush pulse for the selected endpoint |
| force_txerr | output | NUM_EP | Per-endpoint forced transmit error |

## Verification
The bench builds the block with NUM_EP = 4, so the select field is two bits wide and four independent endpoint flags exist. That width is enough to flush one endpoint and commit on another, which shows that forced errors stay separate per endpoint. It also lets zero-length flags be set on two endpoints and cleared on one, and lets firmware try to move the select field to a different endpoint in the middle of an access.

// File: rtl/epfifo_access_ctl.sv
module epfifo_access_ctl #(
  parameter int NUM_EP = 4,
  localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int REG_W = 7 + EPW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NUM_EP-1:0] fifo_ready,
  input  logic              setup_rx,
  input  logic              zlp_rx,
  input  logic [EPW-1:0]    zlp_ep,
  input  logic              fifo_rd_strobe,
  output logic [EPW-1:0]    ep_sel,
  output logic              fifo_commit,
  output logic              fifo_release,
  output logic              fifo_flush,
  output logic [NUM_EP-1:0] force_txerr
);

  logic           req_q, dir_q, setup_q;
  logic [EPW-1:0] sel_q;
  logic           commit_q, release_q, flush_q;
  logic [NUM_EP-1:0] zlp_q, txerr_q;

  wire           w_req   = reg_wdata[0];
  wire           w_dir   = reg_wdata[1];
  wire           w_flush = reg_wdata[2];
  wire           w_setup = reg_wdata[3];
  wire [EPW-1:0] w_sel   = reg_wdata[7 +: EPW];

  wire           held    = reg_wr & req_q & w_req;
  wire           end_wr  = held & dir_q & ~w_dir;
  wire           end_rd  = held & ~dir_q & w_dir;
  wire [EPW-1:0] sel_nxt = (reg_wr & ~req_q) ? w_sel : sel_q;
  wire           do_fl   = reg_wr & w_flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0; dir_q <= 1'b0; sel_q <= '0; setup_q <= 1'b0;
      commit_q <= 1'b0; release_q <= 1'b0; flush_q <= 1'b0;
    end else if (bus_reset) begin
      req_q <= 1'b0; dir_q <= 1'b0; sel_q <= '0; setup_q <= 1'b0;
      commit_q <= 1'b0; release_q <= 1'b0; flush_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        req_q <= w_req;
        dir_q <= w_dir;
      end
      sel_q     <= sel_nxt;
      commit_q  <= end_wr;
      release_q <= end_rd;
      flush_q   <= do_fl;
      if (setup_rx) setup_q <= 1'b1;
      else if (reg_wr && !w_setup) setup_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    localparam logic [EPW-1:0] IDX = EPW'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        zlp_q[i]   <= 1'b0;
        txerr_q[i] <= 1'b0;
      end else if (bus_reset) begin
        zlp_q[i]   <= 1'b0;
        txerr_q[i] <= 1'b0;
      end else begin
        if (zlp_rx && zlp_ep == IDX) zlp_q[i] <= 1'b1;
        else if (fifo_rd_strobe && sel_q == IDX) zlp_q[i] <= 1'b0;
        if (do_fl && sel_nxt == IDX) txerr_q[i] <= 1'b1;
        else if (end_wr && sel_q == IDX) txerr_q[i] <= 1'b0;
      end
    end
  end

  assign reg_rdata    = {sel_q, txerr_q[sel_q], zlp_q[sel_q], fifo_ready[sel_q],
                         setup_q, 1'b0, dir_q, req_q};
  assign ep_sel       = sel_q;
  assign fifo_commit  = commit_q;
  assign fifo_release = release_q;
  assign fifo_flush   = flush_q;
  assign force_txerr  = txerr_q;

  assert_bus_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!req_q && !dir_q && !setup_q && sel_q == '0 && zlp_q == '0 && txerr_q == '0));

  assert_sel_lock_R2: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    ($past(req_q) && !$past(bus_reset)) |-> $stable(sel_q));

  assert_commit_once_R3: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    fifo_commit |=> !fifo_commit);

  assert_end_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    !(fifo_commit && fifo_release));

  assert_flush_marks_R6: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    fifo_flush |-> force_txerr[ep_sel]);

  assert_commit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    (fifo_commit && !fifo_flush) |-> !force_txerr[ep_sel]);

endmodule

// File: tb/sim_epfifo_access_ctl.sv
module sim_epfifo_access_ctl;
  localparam int NUM_EP = 4;
  localparam int EPW = 2;
  localparam int REG_W = 9;

  logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0, reg_wr = 1'b0;
  logic [REG_W-1:0] reg_wdata = '0, reg_rdata;
  logic [NUM_EP-1:0] fifo_ready = '0, force_txerr;
  logic setup_rx = 1'b0, zlp_rx = 1'b0, fifo_rd_strobe = 1'b0;
  logic [EPW-1:0] zlp_ep = '0, ep_sel;
  logic fifo_commit, fifo_release, fifo_flush;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  epfifo_access_ctl #(.NUM_EP(NUM_EP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_ready(fifo_ready),
    .setup_rx(setup_rx), .zlp_rx(zlp_rx), .zlp_ep(zlp_ep),
    .fifo_rd_strobe(fifo_rd_strobe), .ep_sel(ep_sel), .fifo_commit(fifo_commit),
    .fifo_release(fifo_release), .fifo_flush(fifo_flush), .force_txerr(force_txerr));

  function automatic logic [REG_W-1:0] mk(int sel, bit fl, bit dir, bit req, bit stp = 1'b0);
    logic [REG_W-1:0] v = '0;
    v[7 +: EPW] = EPW'(sel);
    v[3] = stp; v[2] = fl; v[1] = dir; v[0] = req;
    return v;
  endfunction

  function automatic logic [13:0] vec(int sel, bit fl, bit dir, bit req,
                                      int esel, bit c, bit r, bit f);
    return {mk(sel, fl, dir, req), EPW'(esel), c, r, f};
  endfunction

  localparam logic [13:0] VEC [12] = '{
    vec(1,0,0,1, 1,0,0,0),
    vec(1,0,1,1, 1,0,1,0),
    vec(1,0,1,0, 1,0,0,0),
    vec(2,0,1,1, 2,0,0,0),
    vec(2,0,0,1, 2,1,0,0),
    vec(2,0,0,0, 2,0,0,0),
    vec(3,1,0,0, 3,0,0,1),
    vec(3,0,1,0, 3,0,0,0),
    vec(3,0,0,0, 3,0,0,0),
    vec(3,0,1,1, 3,0,0,0),
    vec(0,0,0,1, 3,1,0,0),
    vec(3,0,0,0, 3,0,0,0)
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [REG_W-1:0] d);
    @(negedge clk); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic strobe(int which, int ep);
    @(negedge clk);
    zlp_ep = EPW'(ep);
    if (which == 0) setup_rx = 1'b1;
    else if (which == 1) zlp_rx = 1'b1;
    else fifo_rd_strobe = 1'b1;
    @(negedge clk);
    setup_rx = 1'b0; zlp_rx = 1'b0; fifo_rd_strobe = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rdata", reg_rdata, 0);
    chk("R1 reset txerr", force_txerr, 0);

    foreach (VEC[k]) begin
      wr(VEC[k][13:5]);
      chk($sformatf("R3/R4/R5 vec%0d commit", k), fifo_commit, VEC[k][2]);
      chk($sformatf("R4/R5 vec%0d release", k), fifo_release, VEC[k][1]);
      chk($sformatf("R6 vec%0d flush", k), fifo_flush, VEC[k][0]);
      chk($sformatf("R2 vec%0d ep_sel", k), ep_sel, VEC[k][4:3]);
    end
    @(negedge clk);
    chk("R3 commit single cycle", fifo_commit, 0);
    chk("R7 txerr cleared by commit", force_txerr, 4'b0000);

    wr(mk(1,0,1,1));
    chk("R2 readback", reg_rdata[1:0], 2'b11);
    wr(mk(1,0,1,0));

    wr(mk(1,1,0,0));
    chk("R6 flush bit reads 0", reg_rdata[2], 0);
    chk("R6 status bit", reg_rdata[6], 1);
    wr(mk(2,1,0,0));
    chk("R6 flush sets txerr", force_txerr, 4'b0110);
    wr(mk(2,0,1,1));
    wr(mk(2,0,0,1));
    chk("R3 commit ep2", fifo_commit, 1);
    chk("R7 other ep kept", force_txerr, 4'b0010);
    wr(mk(2,0,0,0));

    fifo_ready = 4'b0100;
    @(negedge clk);
    chk("R10 ready sel2", reg_rdata[4], 1);
    wr(mk(1,0,0,0));
    chk("R10 ready sel1", reg_rdata[4], 0);

    strobe(0, 0);
    chk("R8 setup set", reg_rdata[3], 1);
    wr(mk(1,0,0,0,1));
    chk("R8 write 1 keeps", reg_rdata[3], 1);
    wr(mk(1,0,0,0,0));
    chk("R8 write 0 clears", reg_rdata[3], 0);
    @(negedge clk); reg_wdata = mk(1,0,0,0,0); reg_wr = 1'b1; setup_rx = 1'b1;
    @(negedge clk); reg_wr = 1'b0; setup_rx = 1'b0;
    chk("R8 strobe wins", reg_rdata[3], 1);

    strobe(1, 1);
    strobe(1, 2);
    chk("R9 zlp ep1 set", reg_rdata[5], 1);
    strobe(2, 0);
    chk("R9 zlp ep1 cleared", reg_rdata[5], 0);
    wr(mk(2,0,0,0,1));
    chk("R9 zlp ep2 kept", reg_rdata[5], 1);

    wr(mk(3,1,1,1,1));
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
    chk("R1 bus reset rdata", reg_rdata, 0);
    chk("R1 bus reset txerr", force_txerr, 0);
    wr(mk(2,0,0,0,0));
    chk("R1 bus reset zlp", reg_rdata[5], 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule